// File: doc/BRIEF.md
# Display Memory Write Front End

This block sits between a microprocessor bus and the storage of an eight-digit LED display. The processor drives an 8-bit data bus, a register-select line and a write strobe, with no relation to the block's clock. The strobe and the select line are brought into the system clock through synchronizers. Each rising edge of the strobe then counts as exactly one write. With the select line high, the write loads a control word. With it low, the write stores display data.

One strobe serves three kinds of update. A control word alone changes only the settings. A control word that arms a burst blanks the display, and the next eight data writes fill the digits in order. A control word without that flag names one digit, and the data writes after it go to that digit.

Each digit holds two 4-bit banks, one decimal-point bit shared by both banks, and a flag that records whether the digit was last written decoded or raw. A read port lets the scanner fetch the code to show for any digit. The current format, shutdown and blanking settings are also presented to the scanner.

Top module: `disp_write_port`

## Requirements
- R1: After reset, hexSel is 0 (character set B), shutdown is 0 and blankDisp is 0. Decoding is selected and bank A is displayed. Every digit reads rdCode 8'h8F with rdRaw 0 (decimal point off, blank nibble 4'hF).
- R2: A write with modeSel high loads the control word and stores no data. The control word fields are: bit6 = 1 selects hexadecimal; bit5 = 1 selects raw (no-decode); bit4 = 0 selects shutdown; bit3 = 1 selects bank A, 0 selects bank B; bits 2:0 give the digit address, with 0 meaning the first digit; bit7 starts a burst. The new settings appear at the outputs on the third clock edge after wrStrobe rises.
- R3: A control word with bit7 = 1 raises blankDisp. The next eight data writes go to digits 0 through 7 in that order. blankDisp falls with the eighth of them.
- R4: After the eighth burst write, further data writes store nothing and produce no wrPulse until a new control word is written.
- R5: After a control word with bit7 = 0, each data write stores into the digit given by bits 2:0 of that control word.
- R6: A decoded data write puts data bits 3:0 into the nibble of the bank chosen by the control word. It puts data bit7 into the digit's decimal-point bit, shared by both banks, and leaves the other bank's nibble unchanged. A decoded digit reads as {dp, 3'b000, nibble}.
- R7: A raw data write stores all 8 data bits. That digit then reads back the full byte with rdRaw = 1, whatever bank is selected.
- R8: Each digit keeps its decoded or raw flag when later control words change the format.
- R9: The bank bit of the latest control word selects the nibble shown for every decoded digit.
- R10: Control and data writes are accepted while shutdown is 1.
- R11: A strobe held high makes one write only, and wrPulse never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStrobe | input | 1 | Asynchronous write strobe; a write is taken on its rising edge |
| modeSel | input | 1 | 1 = control word, 0 = display data |
| dataBus | input | 8 | Write data |
| rdDigit | input | 3 | Digit selected by the scanner for reading |
| rdCode | output | 8 | Code to show for rdDigit |
| rdRaw | output | 1 | rdDigit was written in raw mode |
| hexSel | output | 1 | 1 = hexadecimal character set, 0 = set B |
| shutdown | output | 1 | Display and scan oscillator off |
| blankDisp | output | 1 | Display blanked while a burst is in progress |
| wrPulse | output | 1 | One-cycle strobe of a data store into memory |
| wrDigit | output | 3 | Digit being stored when wrPulse is high |

## Verification
The assertions watch four things on every cycle. wrPulse never lasts more than one cycle. A burst can only end with a store to the last digit. Settings never change in the same cycle as a data store. A store to the digit under read shows up on rdCode one cycle later, with the full byte for raw stores and the decimal point for decoded ones. The ordering of a burst, the lock-out after it, and the separation of the two banks under later bank switches can only be shown by the bench's write sequences. The same holds for keeping each digit's raw flag and for reads after shutdown writes.

// File: rtl/disp_wr_pkg.sv
package disp_wr_pkg;
  localparam int DIGITS = 8;
  localparam int AW     = $clog2(DIGITS);
  localparam int DATA_W = 8;
  localparam int NIB_W  = 4;

  // control word bit positions (decoded by the sequencer)
  localparam int CW_SEQ  = 7;
  localparam int CW_HEX  = 6;
  localparam int CW_RAW  = 5;
  localparam int CW_RUN  = 4;
  localparam int CW_BANK = 3;

  typedef struct packed {
    logic hex;
    logic raw;
    logic run;
    logic bankA;
  } cfg_t;

  typedef struct packed {
    logic              we;
    logic [AW-1:0]     addr;
    logic [DATA_W-1:0] data;
    logic              raw;
    logic              bankA;
  } wrCmd_t;
endpackage

// File: rtl/disp_wr_ctrl.sv
module disp_wr_ctrl
  import disp_wr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic              modeSel,
  input  logic [DATA_W-1:0] dataBus,
  output wrCmd_t            cmd,
  output cfg_t              cfg,
  output logic              blank
);
  localparam int LAST = DIGITS - 1;

  logic [SYNC_STAGES-1:0] wrSync, modeSync;
  logic wrLast;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) begin
          wrSync   <= '0;
          modeSync <= '0;
        end else begin
          wrSync   <= wrStrobe;
          modeSync <= modeSel;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) begin
          wrSync   <= '0;
          modeSync <= '0;
        end else begin
          wrSync   <= {wrSync[SYNC_STAGES-2:0], wrStrobe};
          modeSync <= {modeSync[SYNC_STAGES-2:0], modeSel};
        end
      end
    end
  endgenerate

  logic wrRise, isCtrl;
  assign wrRise = wrSync[SYNC_STAGES-1] & ~wrLast;
  assign isCtrl = modeSync[SYNC_STAGES-1];

  cfg_t          cfgQ;
  logic [AW-1:0] addrQ, seqPtr;
  logic          seqOn, seqLock;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrLast  <= 1'b0;
      cfgQ    <= '{hex: 1'b0, raw: 1'b0, run: 1'b1, bankA: 1'b1};
      addrQ   <= '0;
      seqPtr  <= '0;
      seqOn   <= 1'b0;
      seqLock <= 1'b0;
      cmd     <= '0;
    end else begin
      wrLast <= wrSync[SYNC_STAGES-1];
      cmd.we <= 1'b0;
      if (wrRise) begin
        if (isCtrl) begin
          cfgQ.hex   <= dataBus[CW_HEX];
          cfgQ.raw   <= dataBus[CW_RAW];
          cfgQ.run   <= dataBus[CW_RUN];
          cfgQ.bankA <= dataBus[CW_BANK];
          addrQ      <= dataBus[AW-1:0];
          seqOn      <= dataBus[CW_SEQ];
          seqPtr     <= '0;
          seqLock    <= 1'b0;
        end else if (!seqLock) begin
          cmd.we    <= 1'b1;
          cmd.data  <= dataBus;
          cmd.raw   <= cfgQ.raw;
          cmd.bankA <= cfgQ.bankA;
          cmd.addr  <= seqOn ? seqPtr : addrQ;
          if (seqOn) begin
            seqPtr <= seqPtr + 1'b1;
            if (seqPtr == AW'(LAST)) begin
              seqOn   <= 1'b0;
              seqLock <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign cfg   = cfgQ;
  assign blank = seqOn;
endmodule

// File: rtl/disp_wr_mem.sv
module disp_wr_mem
  import disp_wr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrCmd_t            cmd,
  input  logic              showBankA,
  input  logic [AW-1:0]     rdDigit,
  output logic [DATA_W-1:0] rdCode,
  output logic              rdRaw
);
  localparam logic [NIB_W-1:0] BLANK_NIB = '1;

  logic [NIB_W-1:0] nibA [DIGITS];
  logic [NIB_W-1:0] nibB [DIGITS];
  logic             dpQ  [DIGITS];
  logic             rawQ [DIGITS];

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    always_ff @(posedge clk) begin
      if (!rstN) begin
        nibA[d] <= BLANK_NIB;
        nibB[d] <= BLANK_NIB;
        dpQ[d]  <= 1'b1;
        rawQ[d] <= 1'b0;
      end else if (cmd.we && cmd.addr == AW'(d)) begin
        dpQ[d]  <= cmd.data[DATA_W-1];
        rawQ[d] <= cmd.raw;
        if (cmd.raw) begin
          nibA[d] <= cmd.data[NIB_W-1:0];
          nibB[d] <= cmd.data[2*NIB_W-1:NIB_W];
        end else if (cmd.bankA) begin
          nibA[d] <= cmd.data[NIB_W-1:0];
        end else begin
          nibB[d] <= cmd.data[NIB_W-1:0];
        end
      end
    end
  end

  logic [NIB_W-1:0] shown;
  always_comb begin
    shown = showBankA ? nibA[rdDigit] : nibB[rdDigit];
    rdRaw = rawQ[rdDigit];
    if (rawQ[rdDigit])
      rdCode = {nibB[rdDigit], nibA[rdDigit]};
    else
      rdCode = {dpQ[rdDigit], {(DATA_W-NIB_W-1){1'b0}}, shown};
  end
endmodule

// File: rtl/disp_write_port.sv
module disp_write_port
  import disp_wr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic              modeSel,
  input  logic [DATA_W-1:0] dataBus,
  input  logic [AW-1:0]     rdDigit,
  output logic [DATA_W-1:0] rdCode,
  output logic              rdRaw,
  output logic              hexSel,
  output logic              shutdown,
  output logic              blankDisp,
  output logic              wrPulse,
  output logic [AW-1:0]     wrDigit
);
  wrCmd_t cmd;
  cfg_t   cfg;

  disp_wr_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .modeSel(modeSel),
    .dataBus(dataBus), .cmd(cmd), .cfg(cfg), .blank(blankDisp)
  );

  disp_wr_mem u_mem (
    .clk(clk), .rstN(rstN), .cmd(cmd), .showBankA(cfg.bankA),
    .rdDigit(rdDigit), .rdCode(rdCode), .rdRaw(rdRaw)
  );

  assign hexSel   = cfg.hex;
  assign shutdown = ~cfg.run;
  assign wrPulse  = cmd.we;
  assign wrDigit  = cmd.addr;
endmodule

// File: rtl/disp_write_port_chk.sv
module disp_write_port_chk
  import disp_wr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input wrCmd_t            cmd,
  input logic [AW-1:0]     rdDigit,
  input logic [DATA_W-1:0] rdCode,
  input logic              rdRaw,
  input logic              shutdown,
  input logic              blankDisp
);
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.we |=> !cmd.we); // R11

  AST_BURST_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(blankDisp) && cmd.we |-> cmd.addr == AW'(DIGITS-1)); // R3

  AST_CTRL_NO_STORE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(shutdown) |-> !cmd.we); // R2

  AST_RAW_STORE: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.we) && $past(cmd.raw) && $stable(rdDigit) && $past(rdDigit) == $past(cmd.addr)
    |-> rdCode == $past(cmd.data) && rdRaw); // R7

  AST_DEC_DP: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.we) && !$past(cmd.raw) && $stable(rdDigit) && $past(rdDigit) == $past(cmd.addr)
    |-> rdCode[DATA_W-1] == $past(cmd.data[DATA_W-1]) && !rdRaw); // R6
endmodule

bind disp_write_port disp_write_port_chk u_chk (
  .clk(clk), .rstN(rstN), .cmd(cmd), .rdDigit(rdDigit), .rdCode(rdCode),
  .rdRaw(rdRaw), .shutdown(shutdown), .blankDisp(blankDisp)
);

// File: tb/tb_disp_write_port.sv
module tb_disp_write_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStrobe = 1'b0;
  logic       modeSel = 1'b0;
  logic [7:0] dataBus = 8'h00;
  logic [2:0] rdDigit = 3'd0;
  logic [7:0] rdCode;
  logic       rdRaw, hexSel, shutdown, blankDisp, wrPulse;
  logic [2:0] wrDigit;

  int nChecks = 0;
  int nFails  = 0;
  int pulseCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  disp_write_port dut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .modeSel(modeSel),
    .dataBus(dataBus), .rdDigit(rdDigit), .rdCode(rdCode), .rdRaw(rdRaw),
    .hexSel(hexSel), .shutdown(shutdown), .blankDisp(blankDisp),
    .wrPulse(wrPulse), .wrDigit(wrDigit)
  );

  always @(posedge clk) if (wrPulse) pulseCnt <= pulseCnt + 1;

  // {mode, data, rdDigit, expCode, expRaw, expHex, expShut}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 8'h1B, 3'd3, 8'h8F, 1'b0, 1'b0, 1'b0},  // R5 single, addr 3, bank A
    {1'b0, 8'h05, 3'd3, 8'h05, 1'b0, 1'b0, 1'b0},  // R5 R6 store to digit 3
    {1'b0, 8'h87, 3'd3, 8'h87, 1'b0, 1'b0, 1'b0},  // R5 same digit again, dp on bit7
    {1'b1, 8'h12, 3'd3, 8'h8F, 1'b0, 1'b0, 1'b0},  // R9 bank B shown
    {1'b0, 8'h09, 3'd2, 8'h09, 1'b0, 1'b0, 1'b0},  // R6 bank B store digit 2
    {1'b1, 8'h1A, 3'd2, 8'h0F, 1'b0, 1'b0, 1'b0},  // R6 bank A untouched, dp shared
    {1'b1, 8'h35, 3'd5, 8'h8F, 1'b0, 1'b0, 1'b0},  // R2 raw format, addr 5
    {1'b0, 8'h5A, 3'd5, 8'h5A, 1'b1, 1'b0, 1'b0},  // R7 raw byte
    {1'b1, 8'h4E, 3'd5, 8'h5A, 1'b1, 1'b1, 1'b1},  // R8 R2 hex, shutdown
    {1'b0, 8'h03, 3'd6, 8'h03, 1'b0, 1'b1, 1'b1},  // R10 write in shutdown
    {1'b1, 8'h5E, 3'd3, 8'h87, 1'b0, 1'b1, 1'b0},  // R9 bank A shown
    {1'b1, 8'h56, 3'd6, 8'h0F, 1'b0, 1'b1, 1'b0}   // R9 bank B of digit 6
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic m, input logic [7:0] d);
    @(negedge clk);
    modeSel = m;
    dataBus = d;
    @(negedge clk);
    wrStrobe = 1'b1;
    repeat (4) @(negedge clk);
    wrStrobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic readDigit(input logic [2:0] dg, output logic [7:0] code, output logic raw);
    @(negedge clk);
    rdDigit = dg;
    #1;
    code = rdCode;
    raw = rdRaw;
  endtask

  initial begin
    logic [7:0] c;
    logic r;
    int p0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 hexSel", {7'd0, hexSel}, 8'd0);
    chk("R1 shutdown", {7'd0, shutdown}, 8'd0);
    chk("R1 blankDisp", {7'd0, blankDisp}, 8'd0);
    for (int i = 0; i < 8; i++) begin
      readDigit(3'(i), c, r);
      chk("R1 digit code", c, 8'h8F);
      chk("R1 digit raw", {7'd0, r}, 8'd0);
    end

    // R2 latency: third edge after strobe rise
    @(negedge clk);
    modeSel = 1'b1;
    dataBus = 8'h58;
    @(negedge clk);
    wrStrobe = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R2 before third edge", {7'd0, hexSel}, 8'd0);
    @(negedge clk);
    chk("R2 at third edge", {7'd0, hexSel}, 8'd1);
    chk("R2 no store", 8'(pulseCnt), 8'd0);
    repeat (2) @(negedge clk);
    wrStrobe = 1'b0;
    repeat (4) @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) begin
      doWrite(VEC[v][22], VEC[v][21:14]);
      readDigit(VEC[v][13:11], c, r);
      chk($sformatf("R5-R10 vec%0d code", v), c, VEC[v][10:3]);
      chk($sformatf("R7 R8 vec%0d raw", v), {7'd0, r}, {7'd0, VEC[v][2]});
      chk($sformatf("R2 vec%0d hex", v), {7'd0, hexSel}, {7'd0, VEC[v][1]});
      chk($sformatf("R10 vec%0d shut", v), {7'd0, shutdown}, {7'd0, VEC[v][0]});
    end

    // R3 decoded burst
    doWrite(1'b1, 8'h98);
    chk("R3 blank on", {7'd0, blankDisp}, 8'd1);
    for (int i = 0; i < 8; i++) begin
      doWrite(1'b0, {i[0], 3'b000, 4'(i + 1)});
      chk("R3 blank during/after", {7'd0, blankDisp}, (i == 7) ? 8'd0 : 8'd1);
    end
    for (int i = 0; i < 8; i++) begin
      readDigit(3'(i), c, r);
      chk("R3 burst order", c, {i[0], 3'b000, 4'(i + 1)});
    end

    // R4 extra write ignored
    p0 = pulseCnt;
    doWrite(1'b0, 8'h0C);
    readDigit(3'd0, c, r);
    chk("R4 digit0 kept", c, 8'h01);
    chk("R4 no pulse", 8'(pulseCnt - p0), 8'd0);

    // R3 R7 raw burst
    doWrite(1'b1, 8'hB8);
    for (int i = 0; i < 8; i++) doWrite(1'b0, 8'hA0 + 8'(i));
    for (int i = 0; i < 8; i++) begin
      readDigit(3'(i), c, r);
      chk("R7 raw burst code", c, 8'hA0 + 8'(i));
      chk("R7 raw burst flag", {7'd0, r}, 8'd1);
    end

    // R11 long strobe gives one write
    doWrite(1'b1, 8'h19);
    @(negedge clk);
    modeSel = 1'b0;
    dataBus = 8'h44;
    p0 = pulseCnt;
    @(negedge clk);
    wrStrobe = 1'b1;
    repeat (30) @(negedge clk);
    chk("R11 one pulse", 8'(pulseCnt - p0), 8'd1);
    wrStrobe = 1'b0;
    repeat (4) @(negedge clk);
    readDigit(3'd1, c, r);
    chk("R11 digit1", c, 8'h04);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule